// File: doc/BRIEF.md
# Banked Interrupt Controller Register Slave

This block is the register front end of a multi-bank interrupt controller. Each bank holds 32 interrupt lines. The block samples the level-sensitive request lines and keeps a pending vector for each bank. It also holds a mask vector, a software-request vector, a per-line fast-route flag and a per-line 6-bit priority. The block presents the pending lines to the arbitration logic already split into a normal view and a fast view. The arbitration logic sits outside this block and returns the winning line numbers of both channels through input ports, so that software can read them.

Software reaches the block through a 32-bit word-wide slave with a 4 KB window and a valid/ready handshake. A write completes in the cycle it is accepted. A read returns registered data one cycle later. Masks and software requests change through separate set and clear addresses, and those addresses read as zero. A control-register write sets the global mask and emits one-cycle acknowledge strobes for the two channels. A system-configuration write can trigger a soft reset, which is also exported as a pulse.

Top module: `bic_regif`

## Requirements
- R1: After reset every mask reads 0xFFFFFFFF, and the pending, software, route and priority state is zero. The global mask and the strobes are low, and the revision at 0x000 reads the REVISION parameter (default 0x21).
- R2: `req_ready_o` is always 1. An accepted read raises `rsp_valid_o` with its data in the next cycle. A write raises no response.
- R3: Bank b occupies 0x080 + 0x20*b, and line l of bank b sits at 0x100 + 0x80*b + 4*l. A bank index at or above NUM_BANKS reads 0, and writes to it have no effect.
- R4: The bank members sit at these offsets: mask +0x04, mask-clear +0x08 and mask-set +0x0C. Writing the mask replaces it, writing mask-clear clears the written bits, and writing mask-set sets them. Both aliases read 0.
- R5: Raw inputs (+0x00) read the request lines sampled at the previous edge. A rising input sets its pending bit. A falling input leaves its pending bit equal to its software bit.
- R6: Software-set (+0x10) ORs the written value into both the software vector and pending, and reads back the software vector. Software-clear (+0x14) clears software bits, after which pending equals the new software vector AND the inputs sampled at that edge. Software-clear reads 0.
- R7: Pending-IRQ (+0x18) reads pending & ~mask & ~route, and pending-FIQ (+0x1C) reads pending & ~mask & route. `pend_irq_o` and `pend_fiq_o` carry the same values.
- R8: A line register holds the priority in bits [7:2] and the fast-route flag in bit 0, and bit 1 reads 0. `prio_o` carries line n at bits [6n+5:6n].
- R9: At control (0x048), bit 2 sets or clears the global mask and reads back at bit 2. Writing bit 0 or bit 1 as 1 pulses `ack_irq_o` or `ack_fiq_o` respectively, for exactly the next cycle.
- R10: Bit 0 of system config (0x010) holds autoidle and reads back. Writing bit 1 as 1 returns every register to its reset value and pulses `soft_reset_o` for the next cycle.
- R11: Status (0x014) always reads 1, and protection (0x04C) always reads 0. Idle (0x050) stores 2 bits. 0x040 and 0x044 read `sir_irq_i` and `sir_fiq_i`.
- R12: Writes to read-only or unmapped addresses change nothing, and unmapped reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Access request |
| req_ready_o | output | 1 | Always ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte address, bits [1:0] ignored |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| irq_lvl_i | input | NUM_BANKS*32 | Level request lines |
| sir_irq_i | input | clog2(NUM_BANKS*32) | Winning normal-channel line number |
| sir_fiq_i | input | clog2(NUM_BANKS*32) | Winning fast-channel line number |
| pend_irq_o | output | NUM_BANKS*32 | Unmasked normal-route pending lines |
| pend_fiq_o | output | NUM_BANKS*32 | Unmasked fast-route pending lines |
| prio_o | output | NUM_BANKS*32*6 | Priority of every line |
| soft_reset_o | output | 1 | Soft-reset pulse |
| ack_irq_o | output | 1 | Normal-channel acknowledge strobe |
| ack_fiq_o | output | 1 | Fast-channel acknowledge strobe |
| global_mask_o | output | 1 | All interrupts globally masked |

## Verification
The bench builds the block with NUM_BANKS = 3 and the default revision of 0x21. With three banks, bank index 3 exists in the address map of both the bank window (0x0E0) and the line window (0x280–0x2FC) but has no storage. The rejection path is therefore reachable from ordinary accesses. The second bank carries a mask pattern that differs from the first, so a stimulus on line 32 shows whether the bank select routes each access to the correct slice.

// File: rtl/bic_pkg.sv
`timescale 1ns/1ps
package bic_pkg;
   localparam int LINES  = 32;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 12;
   localparam int PRIO_W = 6;
   localparam int LINE_W = $clog2(LINES);

   // Word indices inside the global window (0x000..0x07F)
   localparam logic [4:0] W_REV     = 5'h00;
   localparam logic [4:0] W_SYSCFG  = 5'h04;
   localparam logic [4:0] W_SYSSTAT = 5'h05;
   localparam logic [4:0] W_SIRI    = 5'h10;
   localparam logic [4:0] W_SIRF    = 5'h11;
   localparam logic [4:0] W_CTRL    = 5'h12;
   localparam logic [4:0] W_PROT    = 5'h13;
   localparam logic [4:0] W_IDLE    = 5'h14;

   typedef enum logic [2:0] {
      MB_RAW  = 3'd0,
      MB_MASK = 3'd1,
      MB_MCLR = 3'd2,
      MB_MSET = 3'd3,
      MB_SSET = 3'd4,
      MB_SCLR = 3'd5,
      MB_PIRQ = 3'd6,
      MB_PFIQ = 3'd7
   } member_e;

   typedef enum logic [1:0] {
      RG_NONE,
      RG_GLOBAL,
      RG_BANK,
      RG_LINE
   } region_e;

   typedef struct packed {
      region_e              region;
      logic [1:0]           bank;
      member_e              member;
      logic [LINE_W-1:0]    line;
      logic [4:0]           word;
   } dec_t;
endpackage

// File: rtl/bic_decode.sv
`timescale 1ns/1ps
module bic_decode
   import bic_pkg::*;
#(
   parameter int NUM_BANKS = 3
) (
   input  logic [ADDR_W-1:0] addr_i,
   output dec_t              dec_o
);
   logic [2:0] line_bank_raw;
   logic [1:0] unused_low;

   assign unused_low    = addr_i[1:0];
   assign line_bank_raw = addr_i[9:7] - 3'd2;

   always_comb begin
      dec_o        = '0;
      dec_o.region = RG_NONE;
      dec_o.word   = addr_i[6:2];
      dec_o.line   = addr_i[6:2];
      dec_o.member = member_e'(addr_i[4:2]);
      if (addr_i[11:7] == 5'b00000) begin
         dec_o.region = RG_GLOBAL;
      end else if (addr_i[11:7] == 5'b00001) begin
         dec_o.bank = addr_i[6:5];
         if (int'(addr_i[6:5]) < NUM_BANKS) dec_o.region = RG_BANK;
      end else if (addr_i[11:8] == 4'h1 || addr_i[11:8] == 4'h2) begin
         dec_o.bank = line_bank_raw[1:0];
         if (int'(line_bank_raw[1:0]) < NUM_BANKS) dec_o.region = RG_LINE;
      end
   end
endmodule

// File: rtl/bic_bank.sv
`timescale 1ns/1ps
module bic_bank
   import bic_pkg::*;
(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr_i,
   input  logic [LINES-1:0]        irq_lvl_i,
   input  logic                    reg_wr_i,
   input  member_e                 member_i,
   input  logic                    line_wr_i,
   input  logic [LINE_W-1:0]       line_i,
   input  logic [DATA_W-1:0]       wdata_i,
   output logic [LINES-1:0]        raw_o,
   output logic [LINES-1:0]        mask_o,
   output logic [LINES-1:0]        sw_o,
   output logic [LINES-1:0]        pend_irq_o,
   output logic [LINES-1:0]        pend_fiq_o,
   output logic [LINES-1:0]        route_o,
   output logic [LINES*PRIO_W-1:0] prio_o
);
   logic [LINES-1:0]  raw_q, mask_q, sw_q, pend_q, route_q;
   logic [LINES-1:0]  mask_n, sw_n, pend_n, rise, fall, pend_edge;
   logic [PRIO_W-1:0] prio_q [LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= irq_lvl_i;
   end

   always_comb begin
      rise      = irq_lvl_i & ~raw_q;
      fall      = ~irq_lvl_i & raw_q;
      pend_edge = (pend_q & ~fall) | (fall & sw_q) | rise;
      mask_n    = mask_q;
      sw_n      = sw_q;
      pend_n    = pend_edge;
      if (reg_wr_i) begin
         case (member_i)
            MB_MASK: mask_n = wdata_i[LINES-1:0];
            MB_MCLR: mask_n = mask_q & ~wdata_i[LINES-1:0];
            MB_MSET: mask_n = mask_q | wdata_i[LINES-1:0];
            MB_SSET: begin
               sw_n   = sw_q | wdata_i[LINES-1:0];
               pend_n = pend_edge | wdata_i[LINES-1:0];
            end
            MB_SCLR: begin
               sw_n   = sw_q & ~wdata_i[LINES-1:0];
               pend_n = sw_n & irq_lvl_i;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '1;
         sw_q    <= '0;
         pend_q  <= '0;
         route_q <= '0;
         for (int i = 0; i < LINES; i++) prio_q[i] <= '0;
      end else if (clr_i) begin
         mask_q  <= '1;
         sw_q    <= '0;
         pend_q  <= '0;
         route_q <= '0;
         for (int i = 0; i < LINES; i++) prio_q[i] <= '0;
      end else begin
         mask_q <= mask_n;
         sw_q   <= sw_n;
         pend_q <= pend_n;
         if (line_wr_i) begin
            prio_q[line_i]  <= wdata_i[2 +: PRIO_W];
            route_q[line_i] <= wdata_i[0];
         end
      end
   end

   for (genvar g = 0; g < LINES; g++) begin : g_prio
      assign prio_o[g*PRIO_W +: PRIO_W] = prio_q[g];
   end

   assign raw_o      = raw_q;
   assign mask_o     = mask_q;
   assign sw_o       = sw_q;
   assign route_o    = route_q;
   assign pend_irq_o = pend_q & ~mask_q & ~route_q;
   assign pend_fiq_o = pend_q & ~mask_q & route_q;
endmodule

// File: rtl/bic_regif.sv
`timescale 1ns/1ps
module bic_regif
   import bic_pkg::*;
#(
   parameter int         NUM_BANKS = 3,
   parameter logic [7:0] REVISION  = 8'h21
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  req_valid_i,
   output logic                                  req_ready_o,
   input  logic                                  req_write_i,
   input  logic [11:0]                           req_addr_i,
   input  logic [31:0]                           req_wdata_i,
   output logic                                  rsp_valid_o,
   output logic [31:0]                           rsp_rdata_o,
   input  logic [NUM_BANKS*32-1:0]               irq_lvl_i,
   input  logic [$clog2(NUM_BANKS*32)-1:0]       sir_irq_i,
   input  logic [$clog2(NUM_BANKS*32)-1:0]       sir_fiq_i,
   output logic [NUM_BANKS*32-1:0]               pend_irq_o,
   output logic [NUM_BANKS*32-1:0]               pend_fiq_o,
   output logic [NUM_BANKS*32*6-1:0]             prio_o,
   output logic                                  soft_reset_o,
   output logic                                  ack_irq_o,
   output logic                                  ack_fiq_o,
   output logic                                  global_mask_o
);
   localparam int BANK_PRIO_W = LINES * PRIO_W;

   if (NUM_BANKS < 1 || NUM_BANKS > 4) begin : g_bad_banks
      $error("bic_regif: NUM_BANKS must lie in 1..4");
   end
   if (LINES != DATA_W || PRIO_W > 6) begin : g_bad_geom
      $error("bic_regif: line count must equal the data width");
   end

   dec_t        dec;
   logic        wr, rd, srst;
   logic        autoidle_q, gmask_q, ack_irq_q, ack_fiq_q, srst_q, rsp_valid_q;
   logic [1:0]  idle_q;
   logic [31:0] rdata_c, rsp_rdata_q;

   logic [LINES-1:0]       raw_a   [NUM_BANKS];
   logic [LINES-1:0]       mask_a  [NUM_BANKS];
   logic [LINES-1:0]       sw_a    [NUM_BANKS];
   logic [LINES-1:0]       pirq_a  [NUM_BANKS];
   logic [LINES-1:0]       pfiq_a  [NUM_BANKS];
   logic [LINES-1:0]       route_a [NUM_BANKS];
   logic [BANK_PRIO_W-1:0] prio_a  [NUM_BANKS];

   bic_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
      .addr_i (req_addr_i),
      .dec_o  (dec)
   );

   assign req_ready_o = 1'b1;
   assign wr   = req_valid_i & req_write_i;
   assign rd   = req_valid_i & ~req_write_i;
   assign srst = wr && dec.region == RG_GLOBAL && dec.word == W_SYSCFG && req_wdata_i[1];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic bank_wr, line_wr;
      assign bank_wr = wr && dec.region == RG_BANK && dec.bank == 2'(b);
      assign line_wr = wr && dec.region == RG_LINE && dec.bank == 2'(b);

      bic_bank u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .clr_i      (srst),
         .irq_lvl_i  (irq_lvl_i[b*LINES +: LINES]),
         .reg_wr_i   (bank_wr),
         .member_i   (dec.member),
         .line_wr_i  (line_wr),
         .line_i     (dec.line),
         .wdata_i    (req_wdata_i),
         .raw_o      (raw_a[b]),
         .mask_o     (mask_a[b]),
         .sw_o       (sw_a[b]),
         .pend_irq_o (pirq_a[b]),
         .pend_fiq_o (pfiq_a[b]),
         .route_o    (route_a[b]),
         .prio_o     (prio_a[b])
      );

      assign pend_irq_o[b*LINES +: LINES]             = pirq_a[b];
      assign pend_fiq_o[b*LINES +: LINES]             = pfiq_a[b];
      assign prio_o[b*BANK_PRIO_W +: BANK_PRIO_W]     = prio_a[b];
   end

   always_comb begin
      rdata_c = '0;
      case (dec.region)
         RG_GLOBAL: begin
            case (dec.word)
               W_REV:     rdata_c = 32'(REVISION);
               W_SYSCFG:  rdata_c = 32'(autoidle_q);
               W_SYSSTAT: rdata_c = 32'd1;
               W_SIRI:    rdata_c = 32'(sir_irq_i);
               W_SIRF:    rdata_c = 32'(sir_fiq_i);
               W_CTRL:    rdata_c = {29'd0, gmask_q, 2'b00};
               W_IDLE:    rdata_c = 32'(idle_q);
               default:   rdata_c = '0;
            endcase
         end
         RG_BANK: begin
            for (int b = 0; b < NUM_BANKS; b++) begin
               if (dec.bank == 2'(b)) begin
                  case (dec.member)
                     MB_RAW:  rdata_c = raw_a[b];
                     MB_MASK: rdata_c = mask_a[b];
                     MB_SSET: rdata_c = sw_a[b];
                     MB_PIRQ: rdata_c = pirq_a[b];
                     MB_PFIQ: rdata_c = pfiq_a[b];
                     default: rdata_c = '0;
                  endcase
               end
            end
         end
         RG_LINE: begin
            for (int b = 0; b < NUM_BANKS; b++) begin
               if (dec.bank == 2'(b)) begin
                  rdata_c = {24'd0, prio_a[b][dec.line*PRIO_W +: PRIO_W], 1'b0,
                             route_a[b][dec.line]};
               end
            end
         end
         default: rdata_c = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         autoidle_q  <= 1'b0;
         gmask_q     <= 1'b0;
         idle_q      <= '0;
         ack_irq_q   <= 1'b0;
         ack_fiq_q   <= 1'b0;
         srst_q      <= 1'b0;
         rsp_valid_q <= 1'b0;
         rsp_rdata_q <= '0;
      end else begin
         ack_irq_q   <= 1'b0;
         ack_fiq_q   <= 1'b0;
         srst_q      <= srst;
         rsp_valid_q <= rd;
         if (rd) rsp_rdata_q <= rdata_c;
         if (srst) begin
            autoidle_q <= 1'b0;
            gmask_q    <= 1'b0;
            idle_q     <= '0;
         end else if (wr && dec.region == RG_GLOBAL) begin
            case (dec.word)
               W_SYSCFG: autoidle_q <= req_wdata_i[0];
               W_CTRL: begin
                  gmask_q   <= req_wdata_i[2];
                  ack_fiq_q <= req_wdata_i[1];
                  ack_irq_q <= req_wdata_i[0];
               end
               W_IDLE:  idle_q <= req_wdata_i[1:0];
               default: ;
            endcase
         end
      end
   end

   assign rsp_valid_o   = rsp_valid_q;
   assign rsp_rdata_o   = rsp_rdata_q;
   assign soft_reset_o  = srst_q;
   assign ack_irq_o     = ack_irq_q;
   assign ack_fiq_o     = ack_fiq_q;
   assign global_mask_o = gmask_q;
endmodule

// File: rtl/bic_regif_chk.sv
`timescale 1ns/1ps
module bic_regif_chk #(
   parameter int NUM_BANKS = 3
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req_valid_i,
   input logic                    req_write_i,
   input logic [11:0]             req_addr_i,
   input logic [31:0]             req_wdata_i,
   input logic                    rsp_valid_o,
   input logic [31:0]             rsp_rdata_o,
   input logic [NUM_BANKS*32-1:0] pend_irq_o,
   input logic [NUM_BANKS*32-1:0] pend_fiq_o,
   input logic                    soft_reset_o,
   input logic                    ack_irq_o,
   input logic                    ack_fiq_o,
   input logic                    global_mask_o
);
   logic rd, wr;
   assign rd = req_valid_i && !req_write_i;
   assign wr = req_valid_i && req_write_i;

   a_r2_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> rsp_valid_o);
   a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> !rsp_valid_o);
   a_r4_alias_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && (req_addr_i[11:7] == 5'b00001) && (req_addr_i[4:2] == 3'd2 || req_addr_i[4:2] == 3'd3))
      |=> rsp_rdata_o == 32'd0);
   a_r7_views_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_irq_o & pend_fiq_o) == '0);
   a_r9_ack_irq_origin: assert property (@(posedge clk) disable iff (!rst_n)
      ack_irq_o |-> $past(wr && req_addr_i[11:2] == 10'h012 && req_wdata_i[0]));
   a_r9_ack_fiq_origin: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fiq_o |-> $past(wr && req_addr_i[11:2] == 10'h012 && req_wdata_i[1]));
   a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && req_addr_i[11:2] == 10'h004 && req_wdata_i[1]) |=> (soft_reset_o && !global_mask_o));
   a_r11_status_one: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && req_addr_i[11:2] == 10'h005) |=> rsp_rdata_o == 32'd1);
endmodule

bind bic_regif bic_regif_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (.*);

// File: tb/bic_regif_tb.sv
`timescale 1ns/1ps
module bic_regif_tb;
   localparam int NB = 3;
   localparam int SW = $clog2(NB*32);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0, req_write = 1'b0;
   logic [11:0]       req_addr = '0;
   logic [31:0]       req_wdata = '0;
   logic              req_ready, rsp_valid;
   logic [31:0]       rsp_rdata;
   logic [NB*32-1:0]  irq = '0;
   logic [SW-1:0]     sir_irq = '0, sir_fiq = '0;
   logic [NB*32-1:0]  pend_irq, pend_fiq;
   logic [NB*32*6-1:0] prio;
   logic              soft_reset, ack_irq, ack_fiq, global_mask;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bic_regif #(.NUM_BANKS(NB)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
      .req_addr_i(req_addr), .req_wdata_i(req_wdata),
      .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
      .irq_lvl_i(irq), .sir_irq_i(sir_irq), .sir_fiq_i(sir_fiq),
      .pend_irq_o(pend_irq), .pend_fiq_o(pend_fiq), .prio_o(prio),
      .soft_reset_o(soft_reset), .ack_irq_o(ack_irq), .ack_fiq_o(ack_fiq),
      .global_mask_o(global_mask)
   );

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd_chk(input string rq, input logic [11:0] a, input logic [31:0] exp);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2", 32'(rsp_valid), 32'd1);
      chk(rq, rsp_rdata, exp);
   endtask

   typedef struct packed {
      logic        w;
      logic [11:0] a;
      logic [31:0] d;
      logic [31:0] e;
      logic [3:0]  r;
   } vec_t;

   localparam int NV = 28;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 12'h000, 32'h0,        32'h00000021, 4'd1},  // R1 revision
      '{1'b0, 12'h014, 32'h0,        32'h00000001, 4'd11}, // R11 status
      '{1'b0, 12'h084, 32'h0,        32'hFFFFFFFF, 4'd1},  // R1 mask bank0
      '{1'b0, 12'h0C4, 32'h0,        32'hFFFFFFFF, 4'd1},  // R1 mask bank2
      '{1'b1, 12'h088, 32'h0000000F, 32'h0,        4'd4},  // R4 clear
      '{1'b0, 12'h084, 32'h0,        32'hFFFFFFF0, 4'd4},
      '{1'b1, 12'h08C, 32'h00000003, 32'h0,        4'd4},  // R4 set
      '{1'b0, 12'h084, 32'h0,        32'hFFFFFFF3, 4'd4},
      '{1'b0, 12'h088, 32'h0,        32'h00000000, 4'd4},  // R4 alias reads 0
      '{1'b1, 12'h0E4, 32'h0,        32'h0,        4'd3},  // R3 bank 3 absent
      '{1'b0, 12'h0E4, 32'h0,        32'h00000000, 4'd3},
      '{1'b1, 12'h0A4, 32'h12345678, 32'h0,        4'd3},  // R3 bank1 mask
      '{1'b0, 12'h0A4, 32'h0,        32'h12345678, 4'd3},
      '{1'b1, 12'h108, 32'h000000FF, 32'h0,        4'd8},  // R8 line2 bank0
      '{1'b0, 12'h108, 32'h0,        32'h000000FD, 4'd8},
      '{1'b1, 12'h2FC, 32'h000000FF, 32'h0,        4'd3},  // R3 line window bank3
      '{1'b0, 12'h2FC, 32'h0,        32'h00000000, 4'd3},
      '{1'b1, 12'h184, 32'h00000014, 32'h0,        4'd8},  // R8 line1 bank1
      '{1'b0, 12'h184, 32'h0,        32'h00000014, 4'd8},
      '{1'b1, 12'h050, 32'hFFFFFFFF, 32'h0,        4'd11}, // R11 idle
      '{1'b0, 12'h050, 32'h0,        32'h00000003, 4'd11},
      '{1'b1, 12'h04C, 32'h00000001, 32'h0,        4'd11}, // R11 protection
      '{1'b0, 12'h04C, 32'h0,        32'h00000000, 4'd11},
      '{1'b1, 12'h000, 32'h00000055, 32'h0,        4'd12}, // R12 read-only
      '{1'b0, 12'h000, 32'h0,        32'h00000021, 4'd12},
      '{1'b0, 12'h300, 32'h0,        32'h00000000, 4'd12}, // R12 unmapped
      '{1'b1, 12'h010, 32'h00000001, 32'h0,        4'd10}, // R10 autoidle
      '{1'b0, 12'h010, 32'h0,        32'h00000001, 4'd10}
   };

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state at the ports
      chk("R1", 32'(global_mask), 32'd0);
      chk("R1", {30'd0, ack_irq, ack_fiq}, 32'd0);
      chk("R1", 32'(soft_reset), 32'd0);
      chk("R1", 32'(rsp_valid), 32'd0);
      chk("R1", 32'(|{pend_irq, pend_fiq, prio}), 32'd0);
      chk("R2", 32'(req_ready), 32'd1);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].w) wr(VEC[i].a, VEC[i].d);
         else rd_chk($sformatf("R%0d", VEC[i].r), VEC[i].a, VEC[i].e);
      end
      wr(12'h014, 32'h5);
      chk("R2", 32'(rsp_valid), 32'd0);
      rd_chk("R12", 12'h014, 32'd1);
      rd_chk("R12", 12'hFFC, 32'd0);

      // R5 / R7 raw, pending and route views
      wr(12'h084, 32'h0);
      @(negedge clk); irq[4] = 1'b1;
      rd_chk("R5", 12'h080, 32'h10);
      rd_chk("R7", 12'h098, 32'h10);
      chk("R7", pend_irq[31:0], 32'h10);
      wr(12'h110, 32'h1);
      rd_chk("R7", 12'h098, 32'h0);
      rd_chk("R7", 12'h09C, 32'h10);
      chk("R7", pend_fiq[31:0], 32'h10);
      @(negedge clk); irq[4] = 1'b0;
      rd_chk("R5", 12'h09C, 32'h0);

      // R6 software set and clear
      wr(12'h090, 32'h300);
      rd_chk("R6", 12'h090, 32'h300);
      rd_chk("R6", 12'h098, 32'h300);
      @(negedge clk); irq[9] = 1'b1;
      wr(12'h094, 32'h100);
      rd_chk("R6", 12'h090, 32'h200);
      rd_chk("R6", 12'h098, 32'h200);
      rd_chk("R6", 12'h094, 32'h0);
      @(negedge clk); irq[9] = 1'b0;
      rd_chk("R5", 12'h098, 32'h200);
      wr(12'h094, 32'h200);
      rd_chk("R6", 12'h098, 32'h0);

      // R4 / R3 second bank, line 32
      @(negedge clk); irq[32] = 1'b1;
      rd_chk("R3", 12'h0B8, 32'h1);
      wr(12'h0AC, 32'h1);
      rd_chk("R4", 12'h0B8, 32'h0);
      @(negedge clk); irq[32] = 1'b0;

      // R8 exported priorities
      chk("R8", 32'(prio[2*6 +: 6]), 32'h3F);
      chk("R8", 32'(prio[33*6 +: 6]), 32'h05);

      // R9 control register
      wr(12'h048, 32'h7);
      chk("R9", {29'd0, global_mask, ack_irq, ack_fiq}, 32'h7);
      rd_chk("R9", 12'h048, 32'h4);
      chk("R9", {30'd0, ack_irq, ack_fiq}, 32'd0);
      wr(12'h048, 32'h1);
      chk("R9", {29'd0, global_mask, ack_irq, ack_fiq}, 32'h2);

      // R11 arbitration results
      @(negedge clk); sir_irq = 7'd69; sir_fiq = 7'd18;
      rd_chk("R11", 12'h040, 32'd69);
      rd_chk("R11", 12'h044, 32'd18);

      // R10 soft reset
      wr(12'h048, 32'h4);
      wr(12'h010, 32'h2);
      chk("R10", {30'd0, soft_reset, global_mask}, 32'h2);
      rd_chk("R10", 12'h084, 32'hFFFFFFFF);
      rd_chk("R10", 12'h0A4, 32'hFFFFFFFF);
      rd_chk("R10", 12'h108, 32'h0);
      rd_chk("R10", 12'h010, 32'h0);
      rd_chk("R10", 12'h050, 32'h0);
      chk("R10", 32'(soft_reset), 32'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule